// File: doc/BRIEF.md
# Wraparound Bit-Range Mask Generator

This block turns a pair of 6-bit bit positions, a first position and a last position, into a 64-bit mask. Positions are counted from the most significant end of the word: position 0 is the top bit of the mask. When the first position is not past the last one, the mask holds a single run of ones covering both ends and everything between. When the first position lies past the last one, the run wraps: ones fill from the first position down to the low end of the word and carry on from position 0 up to the last position, with a gap of zeros between.

Requests arrive on a valid/ready stream and results leave on another. A request is taken on any rising clock edge where `req_valid` and `req_ready` are both high. Its mask appears on `msk_data` with `msk_valid` high after that edge. A result stays on the port until the consumer takes it with `msk_ready`. Back-pressure is a single slot: `req_ready` is high when the slot is empty or is being emptied in the same cycle. A stalled consumer therefore holds off new requests without losing or reordering any result.

Top module: `range_mask_gen`

## Requirements
- R1: When the first position is less than or equal to the last, mask positions first through last inclusive are one and every other position is zero.
- R2: When the first position is greater than the last, positions from first up to 63 and positions from 0 up to last are one, and the positions strictly between last and first are zero.
- R3: Position p of the mask is bit 63-p of `msk_data`, so position 0 is the most significant bit (first = last = 0 gives 64'h8000_0000_0000_0000).
- R4: When first equals last, exactly one bit of the mask is set.
- R5: First = 0 with last = 63, and any pair where first = last + 1, give an all-ones mask.
- R6: A request taken on a clock edge makes `msk_valid` high after that same edge, with that request's mask on `msk_data`; results leave in the order their requests were taken.
- R7: While `msk_valid` is high and `msk_ready` is low, `msk_valid` stays high and `msk_data` keeps its value on the next edge.
- R8: While `rst_n` is low, `msk_valid` is low and `req_ready` is high on the following edges.
- R9: `req_ready` is high exactly when `msk_valid` is low or `msk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A first/last pair is offered |
| req_ready | output | 1 | The block can take the offered pair this cycle |
| req_first | input | 6 | First position of the run, counted from the most significant bit |
| req_last | input | 6 | Last position of the run, counted from the most significant bit |
| msk_valid | output | 1 | `msk_data` holds a result not yet taken |
| msk_ready | input | 1 | The consumer takes the result this cycle |
| msk_data | output | 64 | The generated mask |

## Verification
A fault in the per-position compare chains or in the wrap select shows up as a wrong mask word in the very next cycle after the offending pair is taken. The bench runs every one of the 4096 first/last pairs, so a single bad position is found. A fault in the result slot shows as a lost, repeated or changed result, or as a wrong `req_ready`. The bench compares these against its own model on every clock, under random gaps on both sides, so such a fault is reported within a cycle of the stall or handshake that exposes it.

// File: rtl/rmask_pkg.sv
package rmask_pkg;
  // Default geometry of the mask word.
  localparam int unsigned MASK_W_DEF = 64;
  localparam int unsigned POS_W_DEF  = $clog2(MASK_W_DEF);

  // Variant of a single-edge mask: ones at or past an index, or ones up to it.
  typedef enum logic {
    EDGE_FROM = 1'b0,
    EDGE_UPTO = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/edge_mask.sv
// One-sided mask: for every MSB-0 position p, bit (W-1-p) tells whether p
// lies at/after idx (EDGE_FROM) or at/before idx (EDGE_UPTO).
module edge_mask
  import rmask_pkg::*;
#(
  parameter int unsigned W     = MASK_W_DEF,
  parameter int unsigned IW    = $clog2(W),
  parameter edge_kind_e  KIND  = EDGE_FROM
) (
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  mask
);
  for (genvar p = 0; p < W; p++) begin : g_pos
    localparam logic [IW-1:0] POS = IW'(p);
    if (KIND == EDGE_FROM) begin : g_from
      assign mask[W-1-p] = (POS >= idx);
    end else begin : g_upto
      assign mask[W-1-p] = (POS <= idx);
    end
  end
endmodule

// File: rtl/range_combine.sv
// Joins the two one-sided masks: intersection for a plain run,
// union when the run wraps past the end of the word.
module range_combine #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [IW-1:0] first,
  input  logic [IW-1:0] last,
  input  logic [W-1:0]  from_first,
  input  logic [W-1:0]  upto_last,
  output logic [W-1:0]  mask
);
  logic wraps;
  always_comb begin
    wraps = (first > last);
    mask  = wraps ? (from_first | upto_last) : (from_first & upto_last);
  end
endmodule

// File: rtl/mask_slot.sv
// Single-entry output register with valid/ready handshake on both sides.
module mask_slot #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  // R7: a stalled result neither vanishes nor changes.
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: an accepted request is presented on the next cycle.
  a_r6_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  // R9: back-pressure rule seen at the pins.
  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/range_mask_gen.sv
module range_mask_gen
  import rmask_pkg::*;
#(
  parameter int unsigned W  = MASK_W_DEF,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [IW-1:0] req_first,
  input  logic [IW-1:0] req_last,
  output logic          msk_valid,
  input  logic          msk_ready,
  output logic [W-1:0]  msk_data
);
  logic [W-1:0] from_first;
  logic [W-1:0] upto_last;
  logic [W-1:0] comb_mask;

  edge_mask #(.W(W), .IW(IW), .KIND(EDGE_FROM)) u_from (
    .idx  (req_first),
    .mask (from_first)
  );

  edge_mask #(.W(W), .IW(IW), .KIND(EDGE_UPTO)) u_upto (
    .idx  (req_last),
    .mask (upto_last)
  );

  range_combine #(.W(W), .IW(IW)) u_join (
    .first      (req_first),
    .last       (req_last),
    .from_first (from_first),
    .upto_last  (upto_last),
    .mask       (comb_mask)
  );

  mask_slot #(.W(W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (comb_mask),
    .out_valid (msk_valid),
    .out_ready (msk_ready),
    .out_data  (msk_data)
  );

  // R1: a plain run has exactly last-first+1 ones.
  a_r1_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first <= req_last) |->
      ($countones(comb_mask) == int'(req_last) - int'(req_first) + 1));

  // R2: a wrapped run leaves a zero gap of first-last-1 positions.
  a_r2_wrap_length: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first > req_last) |->
      ($countones(comb_mask) == int'(W) - (int'(req_first) - int'(req_last) - 1)));

  // R4: equal ends give one set bit.
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first == req_last) |-> ($countones(comb_mask) == 1));

  // R5: full-word cases.
  a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_first == '0 && int'(req_last) == int'(W) - 1) ||
                   int'(req_first) == int'(req_last) + 1)) |-> (&comb_mask));
endmodule

// File: tb/range_mask_gen_test.sv
`timescale 1ns/1ps
module range_mask_gen_test;
  localparam int W  = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [IW-1:0] req_first = '0;
  logic [IW-1:0] req_last = '0;
  logic          msk_valid;
  logic          msk_ready = 1'b0;
  logic [W-1:0]  msk_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  range_mask_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_first (req_first),
    .req_last  (req_last),
    .msk_valid (msk_valid),
    .msk_ready (msk_ready),
    .msk_data  (msk_data)
  );

  // Loop-based reference: position p maps to bit W-1-p.
  function automatic logic [W-1:0] ref_mask(int f, int l);
    logic [W-1:0] m = '0;
    for (int p = 0; p < W; p++) begin
      if (f <= l) m[W-1-p] = (p >= f && p <= l);
      else        m[W-1-p] = (p >= f || p <= l);
    end
    return m;
  endfunction

  function automatic string tag_of(int f, int l);
    if (f == 0 && l == 0)                 return "R3";
    if ((f == 0 && l == W-1) || f == l+1) return "R5";
    if (f == l)                           return "R4";
    if (f > l)                            return "R2";
    return "R1";
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int qf[$];
  int ql[$];
  bit           m_valid = 1'b0;
  logic [W-1:0] m_mask  = '0;
  string        m_tag   = "R1";
  bit           m_stall = 1'b0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int idx = 0;
    // directed pairs first, then the full sweep
    qf = '{0, 0, 5, 63, 10, 20, 40, 0, 33};
    ql = '{0, 63, 4, 0, 10, 30, 3, 1, 32};
    for (int f = 0; f < W; f++)
      for (int l = 0; l < W; l++) begin
        qf.push_back(f);
        ql.push_back(l);
      end

    repeat (3) @(negedge clk);
    // R8: reset state
    check(msk_valid == 1'b0, "R8", W'(msk_valid), '0);
    check(req_ready == 1'b1, "R8", W'(req_ready), W'(1));
    rst_n = 1'b1;

    forever begin
      @(negedge clk);
      check(req_ready == (!m_valid || msk_ready), "R9", W'(req_ready), W'(!m_valid || msk_ready));
      check(msk_valid == m_valid, "R6", W'(msk_valid), W'(m_valid));
      if (m_valid && msk_valid)
        check(msk_data == m_mask, m_stall ? "R7" : m_tag, msk_data, m_mask);
      if (idx >= qf.size() && !m_valid) break;

      if (idx < qf.size()) begin
        req_valid = ($urandom % 4) != 0;
        req_first = IW'(qf[idx]);
        req_last  = IW'(ql[idx]);
      end else begin
        req_valid = 1'b0;
      end
      msk_ready = ($urandom % 4) != 0;
      #1;
      begin
        bit rdy;
        rdy     = !m_valid || msk_ready;
        m_stall = m_valid && !msk_ready;
        if (m_valid && msk_ready) m_valid = 1'b0;
        if (req_valid && rdy) begin
          m_valid = 1'b1;
          m_mask  = ref_mask(qf[idx], ql[idx]);
          m_tag   = tag_of(qf[idx], ql[idx]);
          m_stall = 1'b0;
          idx++;
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule